// File: doc/BRIEF.md
# SPI Slave Byte-Stream Bridge with Escape Stuffing

This block is an SPI slave that carries a byte stream in both directions between an external serial master and an on-chip streaming interface on the system clock. Bytes from the master are filtered before they are delivered. Filler codes are dropped. An escape code is removed, and the byte after it is restored by flipping bit 5 (XOR 0x20). Each surviving byte appears on a valid-only source port.

In the other direction, bytes offered on a ready/valid sink port are sent to the master on MISO. A byte that would look like filler or like an escape is sent as an escape code followed by its bit-5-flipped form. Slots with nothing to send carry filler.

The serial inputs are oversampled by the system clock through synchronizers. SPI clock polarity 0 is the only mode. The master should keep SCLK at or below a quarter of the system clock rate.

Top module: `spi_stuff_bridge`

## Requirements
- R1: While slave select (`ssNIn`, active low) is high, SCLK edges shift no bit in and advance no byte count, so the next selected byte is received whole.
- R2: Bytes travel most significant bit first, 8 bits per byte. MOSI is sampled on the rising SCLK edge, and MISO moves to its next bit after the falling SCLK edge.
- R3: A received byte of 0x4A (filler) produces no output.
- R4: A received 0x4D (escape) produces no output, and the byte received after it is output XOR 0x20. This holds even when that byte is 0x4A or 0x4D.
- R5: Every output byte is marked by `srcValid` high for exactly one system clock cycle.
- R6: If the sink offers no byte when a transmit slot is loaded, the slot carries 0x4A.
- R7: A sink byte equal to 0x4A or 0x4D is sent as 0x4D in one slot and as the byte XOR 0x20 in the next slot. Any other sink byte is sent unchanged in a single slot.
- R8: `snkReady` rises for exactly one cycle per slot load, and never for the slot that carries the second half of an escape pair. A sink byte is accepted only when `snkReady` and `snkValid` are both high.
- R9: Slave select may go high between bytes. A pending receive escape and a pending transmit second half both survive such a gap.
- R10: If slave select goes high after part of a byte has been transferred, the partial receive bits are dropped, and the whole transmit byte of that slot is sent again in the next slot.
- R11: After reset, `srcValid` and `snkReady` are low and the receive escape is clear. The first slot sends 0x4A when the sink is empty, so MISO starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | SPI clock from the master (idle low) |
| mosiIn | input | 1 | Serial data from the master |
| ssNIn | input | 1 | Slave select, active low |
| misoOut | output | 1 | Serial data to the master |
| srcData | output | 8 | Received data byte |
| srcValid | output | 1 | One-cycle strobe marking `srcData` |
| snkData | input | 8 | Byte offered for transmission |
| snkValid | input | 1 | `snkData` is available |
| snkReady | output | 1 | Block takes `snkData` in this cycle |

## Verification
The assertions assume the following about the master:
- SCLK stays low whenever slave select changes.
- Every pair of SCLK edges is at least four system clocks apart.
- Slave select never rises between the eighth rising edge and the falling edge after it.

Under these conditions a completed byte is always followed by a slot load, and two output strobes can never be adjacent. The bench's master keeps within these limits: each SCLK half period lasts eight system clocks, and the lead and lag around slave select last eight clocks each. Idle gaps, partial bytes and SCLK toggling while deselected are added only in ways that respect the same limits.

// File: rtl/spi_stuff_pkg.sv
package spi_stuff_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] IDLE_CODE = 8'h4A;
  localparam logic [BYTE_W-1:0] ESC_CODE  = 8'h4D;
  localparam logic [BYTE_W-1:0] FLIP_MASK = 8'h20;

  // strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic sampleBit;  // qualified rising SCLK edge
    logic byteDone;   // rising edge that completes a byte
    logic shiftOut;   // falling edge inside a byte
    logic loadTx;     // start of a transmit slot
    logic abortSlot;  // select released mid-byte
  } strobe_t;
endpackage

// File: rtl/spi_stuff_ctrl.sv
module spi_stuff_ctrl
  import spi_stuff_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    mosiIn,
  input  logic    ssNIn,
  output logic    mosiBit,
  output strobe_t st
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclkSync, mosiSync, ssNSync;
  logic sclkS, ssNS;
  logic sclkPrev, ssNPrev;
  logic [CNT_W-1:0] bitCnt;
  logic needLoad;
  logic rise, fall;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkSync[g] <= 1'b0;
          mosiSync[g] <= 1'b0;
          ssNSync[g]  <= 1'b1;
        end else if (g == 0) begin
          sclkSync[g] <= sclkIn;
          mosiSync[g] <= mosiIn;
          ssNSync[g]  <= ssNIn;
        end else begin
          sclkSync[g] <= sclkSync[(g == 0) ? 0 : g-1];
          mosiSync[g] <= mosiSync[(g == 0) ? 0 : g-1];
          ssNSync[g]  <= ssNSync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclkS   = sclkSync[LAST];
  assign ssNS    = ssNSync[LAST];
  assign mosiBit = mosiSync[LAST];

  assign rise = sclkS & ~sclkPrev & ~ssNS;
  assign fall = ~sclkS & sclkPrev & ~ssNS;

  always_comb begin
    st.sampleBit = rise;
    st.byteDone  = rise && (bitCnt == CNT_W'(BYTE_W-1));
    st.shiftOut  = fall && (bitCnt != '0);
    st.loadTx    = needLoad && !ssNS;
    st.abortSlot = ssNS && !ssNPrev && (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      ssNPrev  <= 1'b1;
      bitCnt   <= '0;
      needLoad <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      ssNPrev  <= ssNS;
      if (ssNS)             bitCnt <= '0;
      else if (st.byteDone) bitCnt <= '0;
      else if (rise)        bitCnt <= bitCnt + 1'b1;
      if (st.byteDone)      needLoad <= 1'b1;
      else if (st.loadTx)   needLoad <= 1'b0;
    end
  end

  // R6: a finished byte is followed at once by a slot load
  a_r6_load_follows_byte: assert property (@(posedge clk) disable iff (!rstN)
    st.byteDone |=> st.loadTx);

  // R1: a deselected cycle leaves the byte count at zero
  a_r1_deselect_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    (ssNS && $past(ssNS)) |-> (bitCnt == '0));
endmodule

// File: rtl/spi_stuff_dp.sv
module spi_stuff_dp
  import spi_stuff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              mosiBit,
  output logic              misoOut,
  output logic [BYTE_W-1:0] srcData,
  output logic              srcValid,
  input  logic [BYTE_W-1:0] snkData,
  input  logic              snkValid,
  output logic              snkReady
);
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] rxNext;
  logic              rxEsc;

  logic [BYTE_W-1:0] txShift, txCur, txEscByte, txPick;
  logic              txEscPend, snkSpecial;

  // receive path
  assign rxNext = {rxShift, mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxEsc    <= 1'b0;
      srcData  <= '0;
      srcValid <= 1'b0;
    end else begin
      srcValid <= 1'b0;
      if (st.sampleBit) rxShift <= rxNext[BYTE_W-2:0];
      if (st.byteDone) begin
        if (rxEsc) begin
          srcData  <= rxNext ^ FLIP_MASK;
          srcValid <= 1'b1;
          rxEsc    <= 1'b0;
        end else if (rxNext == ESC_CODE) begin
          rxEsc <= 1'b1;
        end else if (rxNext != IDLE_CODE) begin
          srcData  <= rxNext;
          srcValid <= 1'b1;
        end
      end
    end
  end

  // transmit path
  assign snkSpecial = (snkData == IDLE_CODE) || (snkData == ESC_CODE);
  assign snkReady   = st.loadTx && !txEscPend;
  assign misoOut    = txShift[BYTE_W-1];

  always_comb begin
    if (txEscPend)     txPick = txEscByte;
    else if (snkValid) txPick = snkSpecial ? ESC_CODE : snkData;
    else               txPick = IDLE_CODE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= IDLE_CODE;
      txCur     <= IDLE_CODE;
      txEscPend <= 1'b0;
      txEscByte <= '0;
    end else if (st.loadTx) begin
      txShift <= txPick;
      txCur   <= txPick;
      if (txEscPend) begin
        txEscPend <= 1'b0;
      end else if (snkValid && snkSpecial) begin
        txEscPend <= 1'b1;
        txEscByte <= snkData ^ FLIP_MASK;
      end
    end else if (st.abortSlot) begin
      txShift <= txCur;
    end else if (st.shiftOut) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // R5: the output strobe lasts a single cycle
  a_r5_single_cycle_valid: assert property (@(posedge clk) disable iff (!rstN)
    srcValid |=> !srcValid);

  // R5: an output strobe only ever follows a completed byte
  a_r5_valid_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    srcValid |-> $past(st.byteDone));

  // R3: filler outside an escape never reaches the source port
  a_r3_idle_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (st.byteDone && !rxEsc && rxNext == IDLE_CODE) |=> !srcValid);

  // R4: an escape arms the flag and emits nothing
  a_r4_escape_arms: assert property (@(posedge clk) disable iff (!rstN)
    (st.byteDone && !rxEsc && rxNext == ESC_CODE) |=> (rxEsc && !srcValid));

  // R7: an accepted special byte is replaced by an escape with a pending half
  a_r7_special_escaped: assert property (@(posedge clk) disable iff (!rstN)
    (snkReady && snkValid && snkSpecial) |=> (txShift == ESC_CODE && txEscPend));

  // R8: ready is a one-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    snkReady |=> !snkReady);

  // R10: an aborted slot restarts from the whole byte
  a_r10_slot_restored: assert property (@(posedge clk) disable iff (!rstN)
    st.abortSlot |=> (txShift == $past(txCur)));
endmodule

// File: rtl/spi_stuff_bridge.sv
module spi_stuff_bridge
  import spi_stuff_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              mosiIn,
  input  logic              ssNIn,
  output logic              misoOut,
  output logic [BYTE_W-1:0] srcData,
  output logic              srcValid,
  input  logic [BYTE_W-1:0] snkData,
  input  logic              snkValid,
  output logic              snkReady
);
  strobe_t st;
  logic    mosiBit;

  spi_stuff_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkIn  (sclkIn),
    .mosiIn  (mosiIn),
    .ssNIn   (ssNIn),
    .mosiBit (mosiBit),
    .st      (st)
  );

  spi_stuff_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .mosiBit  (mosiBit),
    .misoOut  (misoOut),
    .srcData  (srcData),
    .srcValid (srcValid),
    .snkData  (snkData),
    .snkValid (snkValid),
    .snkReady (snkReady)
  );
endmodule

// File: tb/test_spi_stuff_bridge.sv
module test_spi_stuff_bridge;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ssN = 1'b1;
  logic miso;
  logic [7:0] srcData;
  logic srcValid;
  logic [7:0] snkData = 8'h00;
  logic snkValid = 1'b0;
  logic snkReady;

  always #4 clk = ~clk;  // 125 MHz

  spi_stuff_bridge i_spi_stuff_bridge (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .mosiIn(mosi), .ssNIn(ssN),
    .misoOut(miso), .srcData(srcData), .srcValid(srcValid),
    .snkData(snkData), .snkValid(snkValid), .snkReady(snkReady)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  logic [7:0] rxExp[$];
  logic [7:0] txRawExp[$];
  logic [7:0] snkQ[$];
  bit rxEscModel = 1'b0;
  int readyCount = 0, pushedCount = 0;
  bit pendingPop = 1'b0, prevValid = 1'b0, prevReady = 1'b0;
  logic [7:0] got;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // receive reference: filler dropped, escape flips the following byte
  task automatic modelRx(input logic [7:0] b);
    if (rxEscModel) begin
      rxExp.push_back(b ^ 8'h20);
      rxEscModel = 1'b0;
    end else if (b == 8'h4D) rxEscModel = 1'b1;
    else if (b != 8'h4A) rxExp.push_back(b);
  endtask

  task automatic pushSink(input logic [7:0] b);
    snkQ.push_back(b);
    pushedCount++;
  endtask

  // per-cycle monitor and sink driver, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (pendingPop) begin
        logic [7:0] b;
        b = snkQ.pop_front();
        if (b == 8'h4A || b == 8'h4D) begin
          txRawExp.push_back(8'h4D);
          txRawExp.push_back(b ^ 8'h20);
        end else txRawExp.push_back(b);
        pendingPop = 1'b0;
      end
      snkValid = (snkQ.size() > 0);
      snkData  = (snkQ.size() > 0) ? snkQ[0] : 8'h00;
      if (snkReady) begin
        check(!prevReady, "R8 ready longer than one cycle", 8'(snkReady), 8'h0);
        if (snkValid) begin
          readyCount++;
          pendingPop = 1'b1;
        end
      end
      prevReady = snkReady;
      if (srcValid) begin
        check(!prevValid, "R5 valid longer than one cycle", 8'(srcValid), 8'h0);
        if (rxExp.size() == 0) check(1'b0, "R3/R4 unexpected output byte", srcData, 8'h00);
        else begin
          logic [7:0] e;
          e = rxExp.pop_front();
          check(srcData == e, "R4 output byte", srcData, e);
        end
      end
      prevValid = srcValid;
    end
  end

  // SPI mode 0 master; full bytes are compared against the transmit reference
  task automatic spiByte(input logic [7:0] mo, input int nbits, input bit holdSel,
                         output logic [7:0] mi);
    mi = 8'h00;
    if (ssN) begin
      @(negedge clk) ssN = 1'b0;
      repeat (8) @(negedge clk);
    end
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      mi = {mi[6:0], miso};
      if (nbits == 8 && i == 7) begin
        logic [7:0] e;
        modelRx(mo);
        e = (txRawExp.size() > 0) ? txRawExp.pop_front() : 8'h4A;
        check(mi == e, "R2/R6/R7 MISO byte", mi, e);
      end
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    if (!holdSel) begin
      ssN = 1'b1;
      repeat (12) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    // R11: reset state
    check(srcValid == 1'b0, "R11 srcValid after reset", 8'(srcValid), 8'h0);
    check(snkReady == 1'b0, "R11 snkReady after reset", 8'(snkReady), 8'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(miso == 1'b0, "R11 MISO idle MSB", 8'(miso), 8'h0);

    // R11 / R6: first slot with empty sink is filler; R3: filler in is dropped
    spiByte(8'h4A, 8, 1'b0, got);
    check(got == 8'h4A, "R11 first slot filler", got, 8'h4A);

    // R2 / R7: plain and special sink bytes, mixed receive patterns
    pushSink(8'hC3);
    pushSink(8'h4A);
    pushSink(8'h4D);
    pushSink(8'h10);
    spiByte(8'h12, 8, 1'b0, got);
    spiByte(8'h4D, 8, 1'b0, got);   // R9: escape then deselect gap
    spiByte(8'h6A, 8, 1'b0, got);   // R4: gives 4A
    spiByte(8'h4D, 8, 1'b1, got);
    spiByte(8'h7D, 8, 1'b1, got);   // R4: gives 5D
    spiByte(8'h81, 8, 1'b0, got);   // R2: bit order
    spiByte(8'h4D, 8, 1'b0, got);
    spiByte(8'h4D, 8, 1'b0, got);   // R4: escaped escape gives 6D
    for (int k = 0; k < 4; k++) spiByte(8'h4A, 8, 1'b0, got);

    // R1: SCLK toggles while deselected must not count bits
    mosi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    spiByte(8'h55, 8, 1'b0, got);

    // R10: abort mid-byte; partial dropped, slot byte resent whole
    pushSink(8'h33);
    spiByte(8'h4A, 8, 1'b0, got);   // loads 33 into the next slot
    spiByte(8'hFF, 4, 1'b0, got);
    spiByte(8'h21, 8, 1'b0, got);
    check(got == 8'h33, "R10 resent slot byte", got, 8'h33);

    // R9 / R7: escape second half across a gap, plus held select burst
    pushSink(8'h4D);
    pushSink(8'h4D);
    pushSink(8'h99);
    spiByte(8'h01, 8, 1'b0, got);
    spiByte(8'h02, 8, 1'b0, got);   // gap after this slot's escape
    for (int k = 0; k < 6; k++) spiByte(8'(8'h40 + k), 8, 1'b1, got);
    spiByte(8'h4A, 8, 1'b0, got);
    for (int k = 0; k < 3; k++) spiByte(8'h4A, 8, 1'b0, got);

    repeat (20) @(negedge clk);
    check(rxExp.size() == 0, "R3 receive bytes missing", 8'(rxExp.size()), 8'h0);
    check(txRawExp.size() == 0, "R7 transmit bytes not sent", 8'(txRawExp.size()), 8'h0);
    check(readyCount == pushedCount, "R8 accepted byte count", 8'(readyCount), 8'(pushedCount));
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule